// File: doc/BRIEF.md
# Contention-Aware CPU Clock Generator

This block produces the clock of an 8-bit processor whose RAM is shared with a video serialiser. It does not stall the processor through a ready or wait input. Instead it shapes the processor clock itself: it lengthens a phase or freezes the clock outright, and it does so only at a phase boundary. The master clock runs at four times the full processor rate. Every processor cycle is timed by counting master ticks.

The speed of a cycle depends on two things: what the cycle addresses, and which class of screen mode is in use. A ROM cycle always runs at the full rate. A RAM cycle in a narrow (40-byte-per-line) mode runs at half rate, and the lengthened high phase leaves the remaining slots to video fetches. In a wide (80-byte-per-line) mode, a RAM cycle that is about to begin while pixels are being output keeps the clock low until the border starts. The cycle then finishes as a half-rate cycle. In the border, wide-mode RAM cycles run at half rate.

A companion output, `video_owns_ram`, tells the memory arbiter that the video side may drive the RAM at that moment.

Top module: `contention_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_clk` is low and `video_owns_ram` equals `display_active`.
- R2: A cycle whose `addr_is_ram` is 0 at the last low tick has a high phase of exactly 2 master ticks and a low phase of 2 ticks. ROM code therefore gets one rising edge every 4 ticks, whatever the values of `wide_mode` and `display_active`.
- R3: With `wide_mode` = 0, a cycle whose `addr_is_ram` is 1 at the last low tick has a high phase of 6 master ticks, which is 2 ticks plus one full-rate period of 4 ticks. This gives one rising edge every 8 ticks.
- R4: With `wide_mode` = 1, a RAM cycle whose last low tick sees `display_active` = 1 keeps `cpu_clk` low. No rising edge occurs at a master edge that samples `display_active` = 1.
- R5: A frozen cycle resumes with a rising edge on the first master edge that samples `display_active` = 0. It then finishes with a 6-tick high phase.
- R6: With `wide_mode` = 1, RAM cycles in the border run at the 8-tick rate of R3. For a line of 128 ticks with an 80-tick display, that gives 6 rising edges per line.
- R7: `cpu_clk` changes only at a phase boundary. Every high pulse lasts 2 or 6 ticks, and every low phase lasts at least 2 ticks.
- R8: `video_owns_ram` is 1 exactly when `display_active` is 1 and `cpu_clk` is not in the high phase of a RAM cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the full processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_is_ram | input | 1 | Address decode of the pending cycle: 1 means RAM, 0 means ROM |
| wide_mode | input | 1 | Screen mode class: 1 means 80 bytes per line, 0 means 40 bytes per line |
| display_active | input | 1 | Raster is in the active pixel area (1) or in the border (0) |
| cpu_clk | output | 1 | Gated processor clock |
| video_owns_ram | output | 1 | The video side may use the RAM now |

## Verification
The assertions take three things for granted about the inputs. They assume `addr_is_ram` and `wide_mode` are settled when the last low tick of a cycle is sampled. They assume `display_active` is a synchronous level that changes at most once per master tick. They also assume the address decode stays constant across a frozen cycle. The stimulus respects all three. It changes the access target and the mode class only while the generator is in reset or between measurement windows, and it draws `display_active` from a free-running raster counter updated on the falling master edge. The sweep then covers every pairing of target and mode class over several whole raster lines.

// File: rtl/contention_pkg.sv
package contention_pkg;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_HIGH = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ACC_ROM         = 2'd0,
    ACC_RAM_SLOW    = 2'd1,
    ACC_RAM_BLOCKED = 2'd2
  } access_e;

  // Length of the high phase in master ticks for a given cycle kind.
  function automatic int unsigned high_ticks(input logic slow,
                                             input int unsigned fast_high,
                                             input int unsigned slow_extra);
    return slow ? (fast_high + slow_extra) : fast_high;
  endfunction

  // Classify the pending access from the decode, mode class and raster.
  function automatic access_e classify(input logic is_ram,
                                       input logic wide,
                                       input logic disp);
    if (!is_ram)        return ACC_ROM;
    else if (wide && disp) return ACC_RAM_BLOCKED;
    else                return ACC_RAM_SLOW;
  endfunction

endpackage

// File: rtl/cc_access_class.sv
module cc_access_class
  import contention_pkg::*;
(
  input  logic    addr_is_ram,
  input  logic    wide_mode,
  input  logic    display_active,
  output access_e kind
);

  assign kind = classify(addr_is_ram, wide_mode, display_active);

  // R2: ROM accesses never fall into a slow or blocked class
  always_comb begin
    if (!addr_is_ram)
      assert_rom_fast_R2: assert (kind == ACC_ROM);
  end

endmodule

// File: rtl/cc_phase_gen.sv
module cc_phase_gen
  import contention_pkg::*;
#(
  parameter int unsigned LOW_TICKS  = 2,
  parameter int unsigned FAST_HIGH  = 2,
  parameter int unsigned SLOW_EXTRA = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  access_e kind,
  input  logic    display_active,
  output logic    cpu_clk,
  output logic    slow_cycle,
  output logic    ev_freeze,
  output logic    ev_resume,
  output logic    ev_low_end,
  output logic    ev_high_end
);

  localparam int unsigned SLOW_HIGH = high_ticks(1'b1, FAST_HIGH, SLOW_EXTRA);
  localparam int unsigned MAX_TICKS = (SLOW_HIGH > LOW_TICKS) ? SLOW_HIGH : LOW_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS) + 1;
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HIGH - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HIGH - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;
  logic             slow_q;
  logic [CNT_W-1:0] high_last;

  assign high_last   = slow_q ? SLOW_LAST : FAST_LAST;
  assign ev_low_end  = (phase_q == PH_LOW)  && (cnt_q == LOW_LAST);
  assign ev_high_end = (phase_q == PH_HIGH) && (cnt_q == high_last);
  assign ev_freeze   = ev_low_end && (kind == ACC_RAM_BLOCKED);
  assign ev_resume   = (phase_q == PH_HOLD) && !display_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      slow_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_LOW: begin
          if (ev_freeze) begin
            phase_q <= PH_HOLD;
            slow_q  <= 1'b1;
          end else if (ev_low_end) begin
            phase_q <= PH_HIGH;
            clk_q   <= 1'b1;
            cnt_q   <= '0;
            slow_q  <= (kind != ACC_ROM);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (ev_resume) begin
            phase_q <= PH_HIGH;
            clk_q   <= 1'b1;
            cnt_q   <= '0;
          end
        end
        PH_HIGH: begin
          if (ev_high_end) begin
            phase_q <= PH_LOW;
            clk_q   <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
          clk_q   <= 1'b0;
        end
      endcase
    end
  end

  assign cpu_clk    = clk_q;
  assign slow_cycle = slow_q;

  // R4: the clock stays low for as long as a cycle is frozen
  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |-> !cpu_clk);

  // R4: a master edge that sees the display never starts a blocked high phase
  assert_no_rise_in_display_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HOLD) && display_active) |=> !cpu_clk);

  // R5: leaving the display releases a frozen cycle on the next edge as a slow cycle
  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> (cpu_clk && slow_cycle));

  // R7: no high phase ends before its full length
  assert_no_runt_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HIGH) && !ev_high_end) |=> cpu_clk);

  // R7: every low phase lasts at least its nominal length
  assert_no_runt_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_LOW) && !ev_low_end) |=> !cpu_clk);

endmodule

// File: rtl/cc_bus_owner.sv
module cc_bus_owner (
  input  logic display_active,
  input  logic cpu_clk,
  input  logic slow_cycle,
  output logic video_owns_ram
);

  logic cpu_on_ram;

  assign cpu_on_ram     = cpu_clk && slow_cycle;
  assign video_owns_ram = display_active && !cpu_on_ram;

  // R8: ownership is never granted outside the active display
  always_comb begin
    if (!display_active)
      assert_owner_border_R8: assert (!video_owns_ram);
  end

endmodule

// File: rtl/contention_clkgen.sv
module contention_clkgen
  import contention_pkg::*;
#(
  parameter int unsigned LOW_TICKS  = 2,
  parameter int unsigned FAST_HIGH  = 2,
  parameter int unsigned SLOW_EXTRA = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_is_ram,
  input  logic wide_mode,
  input  logic display_active,
  output logic cpu_clk,
  output logic video_owns_ram
);

  access_e kind;
  logic    slow_cycle;
  logic    ev_freeze;
  logic    ev_resume;
  logic    ev_low_end;
  logic    ev_high_end;

  cc_access_class u_class (
    .addr_is_ram    (addr_is_ram),
    .wide_mode      (wide_mode),
    .display_active (display_active),
    .kind           (kind)
  );

  cc_phase_gen #(
    .LOW_TICKS  (LOW_TICKS),
    .FAST_HIGH  (FAST_HIGH),
    .SLOW_EXTRA (SLOW_EXTRA)
  ) u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .kind           (kind),
    .display_active (display_active),
    .cpu_clk        (cpu_clk),
    .slow_cycle     (slow_cycle),
    .ev_freeze      (ev_freeze),
    .ev_resume      (ev_resume),
    .ev_low_end     (ev_low_end),
    .ev_high_end    (ev_high_end)
  );

  cc_bus_owner u_owner (
    .display_active (display_active),
    .cpu_clk        (cpu_clk),
    .slow_cycle     (slow_cycle),
    .video_owns_ram (video_owns_ram)
  );

  // R1: the processor clock is parked low while in reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> !cpu_clk));

  // R2: a ROM cycle that starts its high phase is a full-rate cycle
  assert_rom_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_low_end && !addr_is_ram) |=> (cpu_clk && !slow_cycle));

  // R3: a narrow-mode RAM cycle starts a stretched high phase
  assert_ram_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_low_end && addr_is_ram && !wide_mode) |=> (cpu_clk && slow_cycle));

  // R6: in the border a wide-mode RAM cycle is never frozen
  assert_border_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_low_end && addr_is_ram && wide_mode && !display_active) |=> (cpu_clk && slow_cycle));

endmodule

// File: tb/contention_clkgen_test.sv
module contention_clkgen_test;

  localparam int LINE   = 128;
  localparam int DISP   = 80;
  localparam int BORDER = LINE - DISP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_is_ram = 1'b0;
  logic wide_mode = 1'b0;
  logic display_active = 1'b1;
  logic cpu_clk;
  logic video_owns_ram;

  always #10 clk = ~clk;

  contention_clkgen uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_is_ram    (addr_is_ram),
    .wide_mode      (wide_mode),
    .display_active (display_active),
    .cpu_clk        (cpu_clk),
    .video_owns_ram (video_owns_ram)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Monitor state, written only by the monitor process.
  int hpos = 0;
  int line_cnt = 0;
  int rises = 0, rises_in_disp = 0, hi2 = 0, hi6 = 0, bad_width = 0;
  int resume_miss = 0, owner_miss = 0;
  int hi_len = 0, lo_len = 0;
  logic prev_clk = 1'b0, prev_disp = 1'b1;
  bit chk_owner = 1'b0;
  logic exp_ram = 1'b0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Sample outputs, then advance the raster, on the falling master edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_clk && !prev_clk) begin
        rises++;
        if (prev_disp && display_active && wide_mode && addr_is_ram) rises_in_disp++;
        if (lo_len < 2) bad_width++;
        lo_len = 0;
      end
      if (!cpu_clk && prev_clk) begin
        if (hi_len == 2) hi2++;
        else if (hi_len == 6) hi6++;
        else bad_width++;
        hi_len = 0;
      end
      if (cpu_clk) hi_len++; else lo_len++;
      if (wide_mode && addr_is_ram && prev_disp && !display_active && !cpu_clk)
        resume_miss++;
      if (chk_owner && (video_owns_ram !== (display_active && !(cpu_clk && exp_ram))))
        owner_miss++;
    end
    prev_clk  = cpu_clk;
    prev_disp = display_active;
    hpos = (hpos == LINE - 1) ? 0 : hpos + 1;
    if (hpos == 0) line_cnt++;
    display_active = (hpos < DISP);
  end

  task automatic measure(input logic ram, input logic wide);
    int start, r0, d0, h2, h6, bw, rm, om, exp_rate;
    rst_n = 1'b0;
    @(negedge clk);
    addr_is_ram = ram;
    wide_mode   = wide;
    exp_ram     = ram;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    start = line_cnt;
    wait (line_cnt == start + 3);
    r0 = rises; d0 = rises_in_disp; h2 = hi2; h6 = hi6; bw = bad_width;
    rm = resume_miss; om = owner_miss;
    chk_owner = 1'b1;
    wait (line_cnt == start + 7);
    chk_owner = 1'b0;
    if (!ram)      exp_rate = LINE / 4;
    else if (!wide) exp_rate = LINE / 8;
    else           exp_rate = BORDER / 8;
    if (!ram)
      check((rises - r0) == 4 * exp_rate, "R2 ROM rate", rises - r0, 4 * exp_rate);
    else if (!wide)
      check((rises - r0) == 4 * exp_rate, "R3 narrow RAM rate", rises - r0, 4 * exp_rate);
    else
      check((rises - r0) == 4 * exp_rate, "R6 wide RAM rate", rises - r0, 4 * exp_rate);
    if (!ram)
      check((hi6 - h6) == 0, "R2 ROM pulses all 2 ticks", hi6 - h6, 0);
    else
      check((hi2 - h2) == 0, "R3 RAM pulses all 6 ticks", hi2 - h2, 0);
    check((bad_width - bw) == 0, "R7 phase widths", bad_width - bw, 0);
    check((rises_in_disp - d0) == 0, "R4 no rise in display", rises_in_disp - d0, 0);
    check((resume_miss - rm) == 0, "R5 resume at border", resume_miss - rm, 0);
    check((owner_miss - om) == 0, "R8 video ownership", owner_miss - om, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state, during display and during border
    #1;
    check(cpu_clk == 1'b0, "R1 clock low in reset", cpu_clk, 0);
    check(video_owns_ram == display_active, "R1 owner follows display", video_owns_ram, display_active);
    wait (hpos == DISP + 2);
    #1;
    check(cpu_clk == 1'b0, "R1 clock low in reset (border)", cpu_clk, 0);
    check(video_owns_ram == display_active, "R1 owner in border", video_owns_ram, display_active);
    // Sweep every pairing of access target and mode class.
    for (int m = 0; m < 4; m++) begin
      measure(m[0], m[1]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule